// File: doc/BRIEF.md
# Flash Busy-Status Read Multiplexer

This block selects the word that a flash controller returns on its host read port. It sits between the array read path and the host. While the controller reports that an internally timed program or erase is running, the block does not return array contents. It returns a synthesised status word instead. One bit of that word shows the inverse of the polled bit of the word being written. A second bit changes value on every read. Software can watch either bit to find out when the operation has finished.

When the controller is idle, the block returns either array data or identification data. In identification mode, a small set of addresses gives a manufacturer code, a device code and the boot-region lock flag. Every read is started by a one-cycle strobe. The result is registered and appears on the output in the next cycle. Between strobes the output holds its value.

Top module: `flash_poll_read`

## Requirements
- R1: After reset, `rdData` is 0x0000, and the first status read of the first operation returns bit 6 = 0.
- R2: When `busyIn` = 0 and `idMode` = 0, a strobe loads `arrayData` into `rdData` one cycle later.
- R3: When `busyIn` = 1 and `opIsErase` = 0, a strobe returns bit 7 equal to the inverse of `lastWord[7]`.
- R4: When `busyIn` = 1 and `opIsErase` = 1, a strobe returns bit 7 = 0.
- R5: While `busyIn` stays 1, bit 6 of successive status reads alternates, starting at 0.
- R6: While busy, every bit of the status word other than bits 7 and 6 reads 0.
- R7: A cycle with `busyIn` = 0 clears the toggle state, so the next operation again starts with bit 6 = 0.
- R8: Once `busyIn` falls, the next read returns the true array word on all 16 bits.
- R9: In identification mode with `busyIn` = 0, the read address selects the returned code. Address 0x0000 returns 0x001F and address 0x0001 returns 0x0087.
- R10: In identification mode, address 0x0002 returns `bootLocked` on bit 0, with 1 meaning locked, and zeros on all other bits.
- R11: The busy status word takes priority over identification data.
- R12: In a cycle without a strobe, `rdData` keeps its value, whatever the other inputs do.
- R13: In identification mode, any address other than 0x0000, 0x0001 and 0x0002 returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busyIn | input | 1 | A program or erase is running |
| opIsErase | input | 1 | The running operation is an erase |
| idMode | input | 1 | Identification readback selected |
| rdStrobe | input | 1 | One-cycle read request |
| rdAddr | input | 16 | Read address |
| lastWord | input | 16 | Most recently loaded program data |
| arrayData | input | 16 | Word read from the array |
| bootLocked | input | 1 | Boot region lock flag |
| rdData | output | 16 | Registered read word |

## Verification
Every result is due exactly one clock after the edge that samples the strobe. The output register and the toggle state both update on that same edge. The bench drives inputs on the falling edge. A monitor records at the rising edge whether a strobe was taken. At the following falling edge it pops the expected word from the scoreboard queue and compares it. The hold check (R12) and the toggle clear (R7) are timed against the same edges: the bench drops `busyIn` for at least one rising edge before it starts a new operation.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef struct packed {
    logic selStatus;
    logic selId;
    logic selArray;
  } rdSelT;
endpackage

// File: rtl/rd_sel_ctrl.sv
module rd_sel_ctrl
  import flash_poll_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  busyIn,
  input  logic  idMode,
  input  logic  rdStrobe,
  output rdSelT rdSel,
  output logic  togState
);
  always_comb begin
    rdSel.selStatus = rdStrobe & busyIn;
    rdSel.selId     = rdStrobe & ~busyIn & idMode;
    rdSel.selArray  = rdStrobe & ~busyIn & ~idMode;
  end

  // toggle flips per busy read, cleared whenever idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            togState <= 1'b0;
    else if (!busyIn)     togState <= 1'b0;
    else if (rdStrobe)    togState <= ~togState;
  end
endmodule

// File: rtl/rd_word_path.sv
module rd_word_path
  import flash_poll_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT = 6,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h001F,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0087,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0002
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdSelT             rdSel,
  input  logic              togState,
  input  logic              opIsErase,
  input  logic [DATA_W-1:0] lastWord,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              bootLocked,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] MFR_ADDR = '0;
  localparam logic [ADDR_W-1:0] DEV_ADDR = ADDR_W'(1);

  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] idWord;

  for (genvar i = 0; i < DATA_W; i++) begin : g_status
    if (i == POLL_BIT) begin : g_poll
      assign statusWord[i] = opIsErase ? 1'b0 : ~lastWord[i];
    end else if (i == TOG_BIT) begin : g_tog
      assign statusWord[i] = togState;
    end else begin : g_zero
      assign statusWord[i] = 1'b0;
    end
  end

  always_comb begin
    idWord = '0;
    if (rdAddr == LOCK_ADDR)     idWord[0] = bootLocked;
    else if (rdAddr == MFR_ADDR) idWord = MFR_CODE;
    else if (rdAddr == DEV_ADDR) idWord = DEV_CODE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (rdSel.selStatus) rdData <= statusWord;
    else if (rdSel.selId)     rdData <= idWord;
    else if (rdSel.selArray)  rdData <= arrayData;
  end
endmodule

// File: rtl/flash_poll_read.sv
module flash_poll_read
  import flash_poll_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyIn,
  input  logic              opIsErase,
  input  logic              idMode,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] lastWord,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              bootLocked,
  output logic [DATA_W-1:0] rdData
);
  rdSelT rdSel;
  logic  togState;

  rd_sel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .idMode(idMode),
    .rdStrobe(rdStrobe), .rdSel(rdSel), .togState(togState)
  );

  rd_word_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .rdSel(rdSel), .togState(togState),
    .opIsErase(opIsErase), .lastWord(lastWord), .arrayData(arrayData),
    .rdAddr(rdAddr), .bootLocked(bootLocked), .rdData(rdData)
  );
endmodule

// File: rtl/flash_poll_read_chk.sv
module flash_poll_read_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busyIn,
  input logic        opIsErase,
  input logic        idMode,
  input logic        rdStrobe,
  input logic [15:0] rdAddr,
  input logic [15:0] lastWord,
  input logic [15:0] arrayData,
  input logic        bootLocked,
  input logic [15:0] rdData,
  input logic        togState,
  input logic [2:0]  rdSelBits
);
  a_r2_array_read: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !busyIn && !idMode |=> rdData == $past(arrayData));
  a_r3_poll_program: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && busyIn && !opIsErase |=> rdData[7] == !$past(lastWord[7]));
  a_r4_poll_erase: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && busyIn && opIsErase |=> rdData[7] == 1'b0);
  a_r5_toggle_flip: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && busyIn |=> togState != $past(togState));
  a_r6_status_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && busyIn |=> (rdData & 16'hFF3F) == 16'h0000);
  a_r7_toggle_clear: assert property (@(posedge clk) disable iff (!rstN)
    !busyIn |=> !togState);
  a_r10_lock_read: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !busyIn && idMode && rdAddr == 16'h0002
    |=> rdData == {15'b0, $past(bootLocked)});
  a_r11_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdSelBits));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));
endmodule

bind flash_poll_read flash_poll_read_chk u_chk (
  .clk(clk), .rstN(rstN), .busyIn(busyIn), .opIsErase(opIsErase),
  .idMode(idMode), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
  .lastWord(lastWord), .arrayData(arrayData), .bootLocked(bootLocked),
  .rdData(rdData), .togState(togState), .rdSelBits(rdSel)
);

// File: tb/test_flash_poll_read.sv
`timescale 1ns/1ps
module test_flash_poll_read;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busyIn = 1'b0;
  logic        opIsErase = 1'b0;
  logic        idMode = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdAddr = '0;
  logic [15:0] lastWord = '0;
  logic [15:0] arrayData = '0;
  logic        bootLocked = 1'b0;
  logic [15:0] rdData;

  int compared = 0;
  int mismatched = 0;
  logic tbTog = 1'b0;
  logic armed = 1'b0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  flash_poll_read i_flash_poll_read (
    .clk(clk), .rstN(rstN), .busyIn(busyIn), .opIsErase(opIsErase),
    .idMode(idMode), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .lastWord(lastWord), .arrayData(arrayData), .bootLocked(bootLocked),
    .rdData(rdData)
  );

  task automatic checkVal(input logic [15:0] act, input logic [15:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: computes expected word from requirements and queues it
  task automatic doRead(input logic [15:0] addr, input string tag);
    logic [15:0] exp;
    @(negedge clk);
    rdAddr = addr;
    rdStrobe = 1'b1;
    exp = '0;
    if (busyIn) begin
      exp[7] = opIsErase ? 1'b0 : ~lastWord[7];
      exp[6] = tbTog;
      tbTog = ~tbTog;
    end else if (idMode) begin
      if (addr == 16'h0000) exp = 16'h001F;
      else if (addr == 16'h0001) exp = 16'h0087;
      else if (addr == 16'h0002) exp = {15'b0, bootLocked};
    end else begin
      exp = arrayData;
    end
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic setBusy(input logic b, input logic erase);
    @(negedge clk);
    busyIn = b;
    opIsErase = erase;
    if (!b) tbTog = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) armed <= rdStrobe;
  always @(negedge clk) begin
    if (armed && expQ.size() > 0) checkVal(rdData, expQ.pop_front(), tagQ.pop_front());
  end

  initial begin
    #100000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    checkVal(rdData, 16'h0000, "R1 reset value");
    rstN = 1'b1;
    @(negedge clk);
    // R2 idle array reads
    arrayData = 16'hA5C3; doRead(16'h0100, "R2 array read a");
    arrayData = 16'h1234; doRead(16'h0200, "R2 array read b");
    // R12 hold without strobe
    @(negedge clk); held = rdData;
    arrayData = 16'hFFFF; idMode = 1'b1; busyIn = 1'b1;
    repeat (3) @(negedge clk);
    checkVal(rdData, held, "R12 hold without strobe");
    busyIn = 1'b0; idMode = 1'b0;
    @(negedge clk);
    // R3 R5 R6 R1 program polling, lastWord bit7 = 1
    lastWord = 16'hFFFF; arrayData = 16'hFFFF;
    setBusy(1'b1, 1'b0);
    doRead(16'h0300, "R1 R5 first toggle 0 R3 bit7");
    doRead(16'h0300, "R5 toggle second R6");
    doRead(16'h0300, "R5 toggle third R6");
    lastWord = 16'h0F70;
    doRead(16'h0300, "R3 bit7 inverse of 0");
    // R8 true data after completion
    arrayData = 16'h0F70;
    setBusy(1'b0, 1'b0);
    doRead(16'h0300, "R8 true data after busy");
    // R7 R4 erase: toggle restarts at 0
    lastWord = 16'h0000;
    setBusy(1'b1, 1'b1);
    doRead(16'h0000, "R7 R4 erase first read");
    doRead(16'h0000, "R4 R5 erase second read");
    doRead(16'h0000, "R4 R5 erase third read");
    setBusy(1'b0, 1'b0);
    arrayData = 16'hFFFF;
    doRead(16'h0000, "R8 erased word");
    // R9 R10 R13 identification
    idMode = 1'b1;
    doRead(16'h0000, "R9 manufacturer code");
    doRead(16'h0001, "R9 device code");
    bootLocked = 1'b0; doRead(16'h0002, "R10 lock clear");
    bootLocked = 1'b1; doRead(16'h0002, "R10 lock set");
    doRead(16'h0005, "R13 other id address");
    // R11 busy over id
    lastWord = 16'h0000;
    setBusy(1'b1, 1'b0);
    doRead(16'h0000, "R11 busy over id");
    doRead(16'h0001, "R11 busy over id toggle");
    setBusy(1'b0, 1'b0);
    doRead(16'h0001, "R9 device code after busy");
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule